// File: doc/BRIEF.md
# PWM Time Base (Prescaled Phase Generator)

This block is the common time base behind a multi-channel pulse-width modulator. A prescaler divides the input clock into beats; one beat lasts `clk_div_i + 1` input clocks. A phase accumulator moves forward once per beat. It wraps after `2^(res_i+1)` beats, which is one PWM cycle, so each output pulse period is `2^(res_i+1) * (clk_div_i + 1)` input clocks.

The phase is a fixed 16-bit fraction of one PWM cycle. The count is left-aligned: every beat adds `2^(15-res_i)`. Only the `res_i+1` most significant bits of `phase_o` carry information, and the rest stay zero. Channel comparators downstream read `phase_o`, `beat_o` and `cycle_start_o`. They compare the phase against their own duty and delay settings and use the cycle-start strobe to pace blink sequences.

A two-state controller drives the block. In IDLE, the prescaler and the phase are held at zero. The START transition (IDLE to RUN) is taken when `cnt_en_i` is sampled high. In RUN, the prescaler counts and the phase advances. The STOP transition (RUN to IDLE) is taken as soon as `cnt_en_i` is sampled low. The counters are cleared on that same edge.

Top module: `ptb_timebase`

## Requirements
- R1: While `rst_ni` is low, and after it is released with `cnt_en_i` low, `phase_o` is 0 and `beat_o` and `cycle_start_o` are 0.
- R2: On the clock after an edge that samples `cnt_en_i` low, `phase_o` is 0 and both strobes are 0. They stay that way while `cnt_en_i` is low, whatever `res_i` and `clk_div_i` do.
- R3: When an edge in IDLE samples `cnt_en_i` high, `beat_o` first goes high `clk_div_i + 1` clocks after that edge. It then goes high once every `clk_div_i + 1` clocks, for one clock each time. With `clk_div_i` = 0 it stays high.
- R4: On every beat, `phase_o` grows by `2^(15-res_i)`, modulo 2^16. It is updated in the same clock in which `beat_o` is high.
- R5: `cycle_start_o` is high exactly on the beats where `phase_o` becomes 0. That happens every `2^(res_i+1)` beats (for example, every 2 beats at `res_i` = 0 and every 65536 beats at `res_i` = 15).
- R6: The `15 - res_i` least significant bits of `phase_o` are zero on every beat.
- R7: Between beats, `phase_o` does not change while the counter is enabled.
- R8: If `clk_div_i` is lowered below the prescaler's current count, the next beat follows one clock later. Later beats then follow the new spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Counter enable; low stops the counter and clears it |
| res_i | input | 4 | Logarithmic resolution; a cycle has 2^(res_i+1) beats |
| clk_div_i | input | 27 | Prescaler value; a beat lasts clk_div_i+1 clocks |
| phase_o | output | 16 | Left-aligned fraction of the current PWM cycle |
| beat_o | output | 1 | High for one clock on each beat |
| cycle_start_o | output | 1 | High on the beat where the phase wraps to zero |

## Verification
A prescaler that holds a stale count moves the first `beat_o` away from clock `clk_div_i + 1`. A wrong count also changes the spacing of later beats, so the error shows within one beat period. A step of the wrong size, or a wrong mask in the accumulator, shows as a wrong `phase_o` on the very next beat. It also shifts the wrap point, so `cycle_start_o` appears on the wrong beat within one PWM cycle. A controller that stays in RUN after the enable drops leaves `phase_o` nonzero one clock after the enable is sampled low.

// File: rtl/ptb_pkg.sv
package ptb_pkg;

    localparam int unsigned PHASE_W = 16;
    localparam int unsigned RES_W   = $clog2(PHASE_W);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ptb_state_e;

    // phase increment per beat for a given resolution code
    function automatic logic [PHASE_W-1:0] step_of(input logic [RES_W-1:0] res);
        return PHASE_W'(1) << (RES_W'(PHASE_W - 1) - res);
    endfunction

    // mask that keeps only the significant (top res+1) phase bits
    function automatic logic [PHASE_W-1:0] keep_mask(input logic [RES_W-1:0] res);
        return ~(step_of(res) - PHASE_W'(1));
    endfunction

endpackage

// File: rtl/ptb_prescaler.sv
module ptb_prescaler #(
    parameter int unsigned DIV_W = 27
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_q;

    // >= so that a lowered divider value ends the beat at once
    assign tick_o = run_i && (cnt_q >= div_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (!run_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

endmodule

// File: rtl/ptb_phase_acc.sv
module ptb_phase_acc
    import ptb_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               run_i,
    input  logic               tick_i,
    input  logic [RES_W-1:0]   res_i,
    output logic [PHASE_W-1:0] phase_o,
    output logic               wrap_o
);

    logic [PHASE_W-1:0] phase_q;
    logic [PHASE_W-1:0] phase_nxt;

    assign phase_nxt = (phase_q + step_of(res_i)) & keep_mask(res_i);
    assign wrap_o    = (phase_nxt == '0);
    assign phase_o   = phase_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            phase_q <= '0;
        end else if (!run_i) begin
            phase_q <= '0;
        end else if (tick_i) begin
            phase_q <= phase_nxt;
        end
    end

endmodule

// File: rtl/ptb_timebase.sv
module ptb_timebase
    import ptb_pkg::*;
#(
    parameter int unsigned DIV_W = 27
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               cnt_en_i,
    input  logic [RES_W-1:0]   res_i,
    input  logic [DIV_W-1:0]   clk_div_i,
    output logic [PHASE_W-1:0] phase_o,
    output logic               beat_o,
    output logic               cycle_start_o
);

    ptb_state_e state_q;
    ptb_state_e state_nxt;
    logic       run;
    logic       tick;
    logic       wrap;
    logic       beat_q;
    logic       cs_q;

    // next-state selection: START and STOP transitions
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE: if (cnt_en_i)  state_nxt = ST_RUN;
            ST_RUN:  if (!cnt_en_i) state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    // state-derived control: counting only in RUN with enable still high
    always_comb begin
        run = 1'b0;
        unique case (state_q)
            ST_IDLE: run = 1'b0;
            ST_RUN:  run = cnt_en_i;
            default: run = 1'b0;
        endcase
    end

    ptb_prescaler #(
        .DIV_W (DIV_W)
    ) u_presc (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (run),
        .div_i  (clk_div_i),
        .tick_o (tick)
    );

    ptb_phase_acc u_acc (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (run),
        .tick_i  (tick),
        .res_i   (res_i),
        .phase_o (phase_o),
        .wrap_o  (wrap)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            beat_q <= 1'b0;
            cs_q   <= 1'b0;
        end else begin
            beat_q <= run && tick;
            cs_q   <= run && tick && wrap;
        end
    end

    assign beat_o        = beat_q;
    assign cycle_start_o = cs_q;

endmodule

// File: rtl/ptb_timebase_chk.sv
module ptb_timebase_chk
    import ptb_pkg::*;
#(
    parameter int unsigned DIV_W = 27
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               cnt_en_i,
    input logic [RES_W-1:0]   res_i,
    input logic [DIV_W-1:0]   clk_div_i,
    input logic [PHASE_W-1:0] phase_o,
    input logic               beat_o,
    input logic               cycle_start_o
);

    // R2
    disable_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cnt_en_i |=> (phase_o == '0) && !beat_o && !cycle_start_o);

    // R5
    wrap_on_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cycle_start_o |-> beat_o && (phase_o == '0));

    // R6
    low_bits_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        beat_o |-> ((phase_o & ~keep_mask($past(res_i))) == '0));

    // R7
    hold_between_beats_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(cnt_en_i) && !beat_o) |-> $stable(phase_o));

endmodule

bind ptb_timebase ptb_timebase_chk #(
    .DIV_W (DIV_W)
) u_ptb_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cnt_en_i      (cnt_en_i),
    .res_i         (res_i),
    .clk_div_i     (clk_div_i),
    .phase_o       (phase_o),
    .beat_o        (beat_o),
    .cycle_start_o (cycle_start_o)
);

// File: tb/test_ptb_timebase.sv
module test_ptb_timebase;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        cnt_en_i = 1'b0;
    logic [3:0]  res_i = 4'd7;
    logic [26:0] clk_div_i = 27'h8000;
    logic [15:0] phase_o;
    logic        beat_o;
    logic        cycle_start_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk_i = ~clk_i;

    ptb_timebase i_ptb_timebase (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .cnt_en_i      (cnt_en_i),
        .res_i         (res_i),
        .clk_div_i     (clk_div_i),
        .phase_o       (phase_o),
        .beat_o        (beat_o),
        .cycle_start_o (cycle_start_o)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            if (fails < 20)
                $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk_i) begin
        cycles++;
        if (cycles > 190000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected below 190000 cycles", cycles);
            finish_run();
        end
    end

    // R1: reset state
    task automatic t_reset();
        rst_ni = 1'b0;
        cnt_en_i = 1'b0;
        repeat (2) @(negedge clk_i);
        check("R1 phase in reset", phase_o, 0);
        check("R1 beat in reset", beat_o, 0);
        check("R1 cycle_start in reset", cycle_start_o, 0);
        rst_ni = 1'b1;
        repeat (3) @(negedge clk_i);
        check("R1 phase after reset", phase_o, 0);
        check("R1 beat after reset", beat_o, 0);
        check("R1 cycle_start after reset", cycle_start_o, 0);
    endtask

    // R3 R4 R5 R6 R7: free run from IDLE, every cycle compared with a beat model
    task automatic t_run(input logic [3:0] res, input logic [26:0] div, input int ncyc);
        longint dv   = longint'(div);
        longint step = longint'(1) << (15 - res);
        longint per  = longint'(1) << (res + 1);
        longint nb   = 0;
        cnt_en_i = 1'b0;
        repeat (2) @(negedge clk_i);
        res_i = res;
        clk_div_i = div;
        cnt_en_i = 1'b1;
        for (int k = 1; k <= ncyc; k++) begin
            logic eb;
            @(negedge clk_i);
            eb = (k >= dv + 2) && (((k - (dv + 2)) % (dv + 1)) == 0);
            if (eb) nb++;
            check("R3 beat timing", beat_o, eb);
            check("R4 R7 phase value", phase_o, (nb * step) & 64'hFFFF);
            check("R5 cycle start", cycle_start_o, eb && ((nb % per) == 0));
            if (eb) check("R6 low bits", phase_o & (step - 1), 0);
        end
    endtask

    // R2: disable clears and stays clear
    task automatic t_disable();
        t_run(4'd2, 27'd3, 30);
        cnt_en_i = 1'b0;
        @(negedge clk_i);
        check("R2 phase cleared", phase_o, 0);
        check("R2 beat cleared", beat_o, 0);
        check("R2 cycle_start cleared", cycle_start_o, 0);
        res_i = 4'd0;
        clk_div_i = 27'd0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk_i);
            check("R2 phase held", phase_o, 0);
            check("R2 beat held", beat_o, 0);
        end
    endtask

    // R8: lowering the divider below the running count
    task automatic t_shrink();
        cnt_en_i = 1'b0;
        repeat (2) @(negedge clk_i);
        res_i = 4'd2;
        clk_div_i = 27'd9;
        cnt_en_i = 1'b1;
        for (int k = 1; k <= 14; k++) begin
            @(negedge clk_i);
            if (k == 6) clk_div_i = 27'd3;
            if (k <= 6) check("R8 no beat before shrink", beat_o, 0);
            else        check("R8 beat after shrink", beat_o, (k == 7) || (k == 11));
            if (k == 7)  check("R8 phase first beat", phase_o, 16'h2000);
            if (k == 11) check("R8 phase second beat", phase_o, 16'h4000);
        end
    endtask

    initial begin
        t_reset();
        t_run(4'd1, 27'd2, 60);
        t_run(4'd0, 27'd0, 20);
        t_run(4'd3, 27'd5, 200);
        t_disable();
        t_shrink();
        t_run(4'd15, 27'd0, 65540);
        t_run(4'd7, 27'h8000, 32800);
        finish_run();
    end

endmodule